// File: doc/BRIEF.md
# Latching Overvoltage Protection Controller

This block guards the output of a multiphase buck regulator against overvoltage. Every clock cycle it compares a sampled differential output-voltage code against a trip level. The trip level depends on the start-up phase. Until a valid voltage-identification code has been seen, the trip level is a fixed code. After that, it is the DAC reference code plus a fixed offset, and the sum saturates at the top of the code range. Codes are unsigned, with 6.25 mV per LSB.

An overvoltage pulls every phase's PWM output low in the same cycle that the comparator reports it. After that, the controller waits for the sensed code to drop below a separate release level, the DAC code plus a smaller offset. It then places all phase outputs in high impedance. If the overvoltage returns, the outputs are pulled low again, and this cycle repeats as often as the overvoltage comes back.

The first trip sets a fault latch that keeps normal PWM blocked. Changes to the reference code or to the valid flag do not clear it. Only a rising edge on either enable input, or the supply-good (POR) input going low, clears it. While the supply-good input is high, protection works whether or not the regulator is enabled. The drive state for each phase is brought out as a two-bit code, together with the gated PWM level and an output-enable.

Top module: `ovp_latch_ctrl`

## Requirements
- R1: During and after the synchronous active-low reset, with no overvoltage present, the drive state is 00 (normal), the fault flag is 0, every output-enable is 1 and every PWM output follows its request.
- R2: While the VID-valid input is 0, an overvoltage exists exactly when the sensed code is strictly greater than 204. A sensed code of 204 is not an overvoltage.
- R3: While the VID-valid input is 1, an overvoltage exists exactly when the sensed code is strictly greater than the DAC code plus 28.
- R4: In the cycle an overvoltage is present with supply-good high, the drive state is 01 (forced low) without waiting for a clock edge, all PWM outputs are 0, all output-enables are 1 and the fault flag is 1.
- R5: When the registered state is forced-low, there is no overvoltage and the sensed code is strictly below the DAC code plus 12 (saturated), the drive state becomes 10 (high impedance) after the next clock edge, with all output-enables 0.
- R6: An overvoltage during the high-impedance state returns the drive state to 01 at once, and a later release again leads to 10. This repeats without limit.
- R7: Once tripped, the drive state never returns to 00 and the fault flag stays 1 until a clear. Changing the DAC code or the VID-valid input does not clear it. While the fault is set, all PWM outputs are 0.
- R8: A 0-to-1 transition on either enable input, seen at a clock edge, clears the fault and returns the state to 00 after that edge. A 1-to-0 transition clears nothing. If an overvoltage is present at that edge, the state stays 01 and the fault stays set.
- R9: While supply-good is 0, the drive state is 00 and no overvoltage is reported. After one clock edge with supply-good 0, the fault flag is 0.
- R10: With supply-good high, protection acts on an overvoltage even when both enable inputs are 0.
- R11: The trip-level and release-level additions saturate at the maximum code (255 for 8-bit codes). With a DAC code near the top of the range, a sensed code of 255 is never an overvoltage once VID is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Supply above the power-on-reset threshold |
| enable_main | input | 1 | First regulator enable; a rising edge clears the latch |
| enable_aux | input | 1 | Second regulator enable; a rising edge clears the latch |
| vid_ok | input | 1 | A valid VID has been detected (soft-start trip phase over) |
| vsense_code | input | CODE_W | Sampled differential output voltage code |
| dac_code | input | CODE_W | DAC reference code |
| pwm_req | input | NPH | Modulator PWM level for each phase |
| pwm_out | output | NPH | Gated PWM level for each phase |
| pwm_oe | output | NPH | Output-enable for each phase (0 = high impedance) |
| drv_state | output | 2 | Drive state: 00 normal, 01 forced low, 10 high impedance |
| ov_fault | output | 1 | Overvoltage fault flag to the sequencer |

## Verification
The assertions check four things on every cycle. A live overvoltage must lead to the forced-low state at the next edge. A release must lead to high impedance. The latch must hold until an enable rises or supply-good drops, and PWM must stay blocked while the fault is set. Thresholds must never wrap below the DAC code. The bench's sweeps are what show the exact trip boundaries against 204 and against the DAC code plus 28, including saturation at the top code. Its scenarios show the repeating low/high-impedance cycle and that VID changes do not clear the latch. They also show the difference between a falling and a rising enable.

// File: rtl/ovp_pkg.sv
// Shared types for the overvoltage protection controller.
// Assumes: drive state encoding is fixed at two bits; 11 is never produced.
package ovp_pkg;
    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_LOW    = 2'b01,
        DRV_HIZ    = 2'b10
    } drv_state_e;
endpackage

// File: rtl/ovp_thresh.sv
// Computes the trip level and the release level from the DAC code.
// Trip level: a fixed code before VID is valid, DAC + TRIP_OFS afterwards.
// Release level: DAC + REL_OFS. Both additions saturate at the code maximum.
// Assumes: FIX_TRIP, TRIP_OFS and REL_OFS fit in CODE_W bits.
module ovp_thresh #(
    parameter int CODE_W   = 8,
    parameter int FIX_TRIP = 204,
    parameter int TRIP_OFS = 28,
    parameter int REL_OFS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_ok,
    input  logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] trip_thr,
    output logic [CODE_W-1:0] rel_thr
);
    localparam int SUM_W = CODE_W + 1;
    localparam logic [SUM_W-1:0]  TRIP_OFS_W = SUM_W'(TRIP_OFS);
    localparam logic [SUM_W-1:0]  REL_OFS_W  = SUM_W'(REL_OFS);
    localparam logic [CODE_W-1:0] FIX_W      = CODE_W'(FIX_TRIP);
    localparam logic [CODE_W-1:0] CODE_MAX   = {CODE_W{1'b1}};

    logic [SUM_W-1:0]  trip_sum;
    logic [SUM_W-1:0]  rel_sum;
    logic [CODE_W-1:0] trip_dac;

    // Widened additions so the carry shows the overflow.
    always_comb begin
        trip_sum = {1'b0, dac_code} + TRIP_OFS_W;
        rel_sum  = {1'b0, dac_code} + REL_OFS_W;
    end

    // Saturate the sums and pick the trip level for the current phase.
    always_comb begin
        trip_dac = trip_sum[CODE_W] ? CODE_MAX : trip_sum[CODE_W-1:0];
        rel_thr  = rel_sum[CODE_W]  ? CODE_MAX : rel_sum[CODE_W-1:0];
        trip_thr = vid_ok ? trip_dac : FIX_W;
    end

    // R11: saturation never wraps a level below the reference.
    assert_sat_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vid_ok |-> (trip_thr >= dac_code) && (rel_thr >= dac_code));
endmodule

// File: rtl/ovp_compare.sv
// Digital comparators: the overvoltage is a strict exceed of the trip
// level, and the release is a strict drop below the release level.
// Assumes: the overvoltage report is gated off while the supply is below POR.
module ovp_compare #(
    parameter int CODE_W = 8
) (
    input  logic              por_ok,
    input  logic [CODE_W-1:0] vsense_code,
    input  logic [CODE_W-1:0] trip_thr,
    input  logic [CODE_W-1:0] rel_thr,
    output logic              ov_live,
    output logic              below_rel
);
    // Compare the sensed code against both levels.
    always_comb begin
        ov_live   = por_ok && (vsense_code > trip_thr);
        below_rel = vsense_code < rel_thr;
    end
endmodule

// File: rtl/ovp_fsm.sv
// Protection state machine and fault latch.
// A live overvoltage forces low in the same cycle and is registered.
// The forced-low state moves to high impedance after the release.
// A clear happens on a rising edge of either enable or while the supply is low.
// Assumes: enables are synchronous to clk.
module ovp_fsm
    import ovp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       enable_main,
    input  logic       enable_aux,
    input  logic       ov_live,
    input  logic       below_rel,
    output drv_state_e drv_state,
    output logic       fault
);
    drv_state_e st_q;
    logic       fault_q;
    logic [1:0] en_q;
    logic       clr;

    // Remember the enables to detect their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 2'b00;
        else        en_q <= {enable_aux, enable_main};
    end

    // A clear request is a 0-to-1 transition on either enable.
    always_comb clr = |({enable_aux, enable_main} & ~en_q);

    // State and latch update. Supply loss wins, then a trip, then a clear,
    // then the release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= DRV_NORMAL;
            fault_q <= 1'b0;
        end else if (!por_ok) begin
            st_q    <= DRV_NORMAL;
            fault_q <= 1'b0;
        end else if (ov_live) begin
            st_q    <= DRV_LOW;
            fault_q <= 1'b1;
        end else if (clr) begin
            st_q    <= DRV_NORMAL;
            fault_q <= 1'b0;
        end else if (st_q == DRV_LOW && below_rel) begin
            st_q    <= DRV_HIZ;
        end
    end

    // Output state: a live trip overrides; no protection without supply.
    always_comb begin
        if (ov_live)      drv_state = DRV_LOW;
        else if (!por_ok) drv_state = DRV_NORMAL;
        else              drv_state = st_q;
        fault = fault_q | ov_live;
    end

    // R4: a live trip is registered as forced low.
    assert_trip_registers_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ov_live |=> st_q == DRV_LOW && fault_q);

    // R5: forced low with the release met and no clear goes to high impedance.
    assert_release_to_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (por_ok && st_q == DRV_LOW && !ov_live && below_rel && !clr) |=> st_q == DRV_HIZ);

    // R7: the latch holds with the supply up and no clear.
    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && por_ok && !clr) |=> fault_q);

    // R8: a clear without a trip returns to normal.
    assert_enable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && por_ok && !ov_live) |=> (st_q == DRV_NORMAL) && !fault_q);

    // R9: supply loss clears the latch.
    assert_por_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> !fault_q);
endmodule

// File: rtl/ovp_phase_drv.sv
// Drive gating for a single phase. Normal passes the modulator level,
// forced low drives 0, and high impedance drops the output-enable.
// Assumes: the driver reads pwm_oe == 0 as the tristate request.
module ovp_phase_drv
    import ovp_pkg::*;
(
    input  drv_state_e drv_state,
    input  logic       pwm_req,
    output logic       pwm_out,
    output logic       pwm_oe
);
    // Gate the level and the enable from the shared drive state.
    always_comb begin
        pwm_out = (drv_state == DRV_NORMAL) && pwm_req;
        pwm_oe  = (drv_state != DRV_HIZ);
    end
endmodule

// File: rtl/ovp_latch_ctrl.sv
// Top of the latching overvoltage protection controller.
// It chains threshold selection, comparison, the state machine and one
// drive gate for each phase.
// Assumes: all inputs are synchronous to clk; codes are unsigned, 6.25 mV/LSB.
module ovp_latch_ctrl
    import ovp_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int NPH      = 4,
    parameter int FIX_TRIP = 204,
    parameter int TRIP_OFS = 28,
    parameter int REL_OFS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              enable_main,
    input  logic              enable_aux,
    input  logic              vid_ok,
    input  logic [CODE_W-1:0] vsense_code,
    input  logic [CODE_W-1:0] dac_code,
    input  logic [NPH-1:0]    pwm_req,
    output logic [NPH-1:0]    pwm_out,
    output logic [NPH-1:0]    pwm_oe,
    output logic [1:0]        drv_state,
    output logic              ov_fault
);
    logic [CODE_W-1:0] trip_thr;
    logic [CODE_W-1:0] rel_thr;
    logic              ov_live;
    logic              below_rel;
    drv_state_e        st;

    ovp_thresh #(
        .CODE_W(CODE_W), .FIX_TRIP(FIX_TRIP),
        .TRIP_OFS(TRIP_OFS), .REL_OFS(REL_OFS)
    ) u_thresh (
        .clk(clk), .rst_n(rst_n), .vid_ok(vid_ok), .dac_code(dac_code),
        .trip_thr(trip_thr), .rel_thr(rel_thr)
    );

    ovp_compare #(.CODE_W(CODE_W)) u_cmp (
        .por_ok(por_ok), .vsense_code(vsense_code),
        .trip_thr(trip_thr), .rel_thr(rel_thr),
        .ov_live(ov_live), .below_rel(below_rel)
    );

    ovp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
        .enable_main(enable_main), .enable_aux(enable_aux),
        .ov_live(ov_live), .below_rel(below_rel),
        .drv_state(st), .fault(ov_fault)
    );

    // One drive gate per phase.
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        ovp_phase_drv u_drv (
            .drv_state(st), .pwm_req(pwm_req[p]),
            .pwm_out(pwm_out[p]), .pwm_oe(pwm_oe[p])
        );
    end

    always_comb drv_state = st;

    // R7: PWM stays blocked while the fault is reported.
    assert_pwm_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (por_ok && ov_fault) |-> pwm_out == '0);
endmodule

// File: tb/tb_ovp_latch_ctrl.sv
module tb_ovp_latch_ctrl;
    localparam int CODE_W = 8;
    localparam int NPH    = 3;

    logic              clk = 1'b0;
    logic              rst_n, por_ok, enable_main, enable_aux, vid_ok;
    logic [CODE_W-1:0] vsense_code, dac_code;
    logic [NPH-1:0]    pwm_req, pwm_out, pwm_oe;
    logic [1:0]        drv_state;
    logic              ov_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ovp_latch_ctrl #(.CODE_W(CODE_W), .NPH(NPH)) dut (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
        .enable_main(enable_main), .enable_aux(enable_aux), .vid_ok(vid_ok),
        .vsense_code(vsense_code), .dac_code(dac_code), .pwm_req(pwm_req),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe), .drv_state(drv_state),
        .ov_fault(ov_fault)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int trip_of(input int vv, input int dac);
        int s;
        s = dac + 28;
        if (s > 255) s = 255;
        return vv ? s : 204;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dacs[6] = '{0, 100, 180, 227, 228, 255};
        rst_n = 0; por_ok = 1; enable_main = 1; enable_aux = 1; vid_ok = 0;
        vsense_code = 0; dac_code = 0; pwm_req = 3'b101;
        repeat (3) tick();
        rst_n = 1;
        tick(); #1;
        // R1 reset state
        chk("R1 state", drv_state, 0);
        chk("R1 fault", ov_fault, 0);
        chk("R1 oe", pwm_oe, 3'b111);
        chk("R1 out", pwm_out, 3'b101);

        // R2, R3, R11: trip-boundary sweeps with a latch clear before each point
        for (int vv = 0; vv < 2; vv++) begin
            for (int di = 0; di < 6; di++) begin
                for (int v = 0; v < 256; v++) begin
                    tick(); por_ok = 0;
                    tick(); por_ok = 1; vid_ok = vv[0]; dac_code = dacs[di][7:0];
                    vsense_code = v[7:0];
                    #1;
                    if (vv == 0)
                        chk("R2 trip sweep", drv_state, (v > 204) ? 1 : 0);
                    else if (dacs[di] >= 227)
                        chk("R11 saturated sweep", drv_state, (v > trip_of(1, dacs[di])) ? 1 : 0);
                    else
                        chk("R3 trip sweep", drv_state, (v > trip_of(1, dacs[di])) ? 1 : 0);
                end
            end
        end

        // R4, R5: trip then release
        tick(); por_ok = 0;
        tick(); por_ok = 1; vid_ok = 1; dac_code = 160; vsense_code = 100; #1;
        chk("R3 below trip", drv_state, 0);
        tick(); vsense_code = 189; #1;
        chk("R4 state", drv_state, 1);
        chk("R4 out", pwm_out, 0);
        chk("R4 oe", pwm_oe, 3'b111);
        chk("R4 fault", ov_fault, 1);
        tick(); vsense_code = 180; #1;
        chk("R5 hold above release", drv_state, 1);
        tick(); vsense_code = 171; #1;
        chk("R5 release waits edge", drv_state, 1);
        tick(); #1;
        chk("R5 hiz", drv_state, 2);
        chk("R5 oe", pwm_oe, 0);
        chk("R5 fault", ov_fault, 1);

        // R7: VID changes do not clear
        tick(); dac_code = 100; vid_ok = 0; vsense_code = 50;
        tick(); vid_ok = 1;
        tick(); tick(); #1;
        chk("R7 state kept", drv_state, 2);
        chk("R7 fault kept", ov_fault, 1);
        chk("R7 out blocked", pwm_out, 0);

        // R6: repeat the cycle
        vsense_code = 130; #1;
        chk("R6 re-trip", drv_state, 1);
        tick(); vsense_code = 0;
        tick(); #1;
        chk("R6 re-release", drv_state, 2);

        // R8: falling enable does nothing, rising clears
        enable_main = 0;
        tick(); #1;
        chk("R8 fall no clear", drv_state, 2);
        enable_main = 1;
        tick(); #1;
        chk("R8 rise clears state", drv_state, 0);
        chk("R8 rise clears fault", ov_fault, 0);
        chk("R8 out restored", pwm_out, 3'b101);

        // R10: protection with both enables low
        enable_main = 0; enable_aux = 0;
        tick(); vsense_code = 210; #1;
        chk("R10 trip while disabled", drv_state, 1);
        chk("R10 fault", ov_fault, 1);
        tick(); vsense_code = 0;
        tick(); tick(); #1;
        chk("R10 hiz while disabled", drv_state, 2);
        enable_aux = 1;
        tick(); #1;
        chk("R8 aux rise clears", drv_state, 0);
        enable_main = 1;
        tick();

        // R8: a clear with overvoltage present keeps the trip
        enable_aux = 0;
        tick(); vsense_code = 200; enable_aux = 1; #1;
        chk("R8 trip at clear", drv_state, 1);
        tick(); #1;
        chk("R8 ov beats clear state", drv_state, 1);
        chk("R8 ov beats clear fault", ov_fault, 1);
        vsense_code = 0;
        tick(); tick(); #1;
        chk("R6 release after clear attempt", drv_state, 2);

        // R9: supply loss
        por_ok = 0; #1;
        chk("R9 state with supply low", drv_state, 0);
        tick(); #1;
        chk("R9 fault cleared", ov_fault, 0);
        vsense_code = 250; #1;
        chk("R9 no protection state", drv_state, 0);
        chk("R9 no protection fault", ov_fault, 0);
        por_ok = 1; #1;
        chk("R9 protection back", drv_state, 1);
        tick(); vsense_code = 0; por_ok = 0;
        tick(); por_ok = 1; #1;
        chk("R9 cleared after cycle", drv_state, 0);
        chk("R9 fault after cycle", ov_fault, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule